// File: doc/BRIEF.md
# Sigma-Delta Dual-Stream Output Front End

This block sits between two first-order 1-bit sigma-delta modulators, one for line voltage and one for line current, and the single serial pin pair that carries their results off the die. It runs directly on the external measurement clock. From that clock it derives five control clocks for the modulators: two non-overlapping conversion phases and three chopper clocks, one for the voltage path and two for the current path. It samples each modulator bitstream once every two measurement clock cycles. It then time-interleaves the two held bits on the two levels of the measurement clock, so that a downstream demultiplexer needs only one data wire and the clock it already drives.

The voltage slot can be switched off with an enable input. A disabled slot carries a constant 0, while the current slot keeps running. An active-low supply-good/reset input holds the whole block quiet. Nominal measurement clocks are 1.024 MHz or 2.048 MHz. Usable ranges are 1.0–1.228 MHz for low-precision use and 2.0–2.458 MHz for high-precision use. The serial output has to be valid within 40 ns of a clock edge, which is why the slot selection is a single multiplexer steered by the clock level rather than a retimed signal.

Top module: `sdfe_top`

## Requirements
- R1: While `rst_n` is low, `dat` is 0 and `datn` is 1, and `ph1`, `ph2`, `vchop`, `cchop_a` and `cchop_b` are all 0. This holds independently of the clock and of the data and enable inputs.
- R2: While `clk` is high and `v_en` is 1, `dat` equals the most recently sampled voltage bit.
- R3: While `clk` is low, `dat` equals the most recently sampled current bit, whatever the value of `v_en`.
- R4: `datn` is always the logical inverse of `dat`.
- R5: The first rising edge after `rst_n` rises only starts the block and samples nothing. Counting that edge as edge 1, `v_bs` is sampled on edges 2, 4, 6, … and `c_bs` on edges 3, 5, 7, …, so each stream is sampled at half the clock rate. Every sampled bit is held for two clock cycles. Until its first sample, each held bit reads 0.
- R6: `ph1` is high during the high half of each clock cycle that begins with a voltage sample. `ph2` is high during the high half of every other running cycle. The two are never high together, and both are low while `clk` is low.
- R7: `cchop_a` and `cchop_b` are square waves with a period of four clock cycles. `cchop_a` rises on edge 2 and falls on edge 4. `cchop_b` follows one clock cycle later, so the two never change on the same edge. `vchop` changes only on voltage-sampling edges and matches `cchop_a`.
- R8: While `v_en` is 0, the high-level slot of `dat` is 0 (and `datn` 1), whatever the voltage bitstream is.
- R9: Pulling `rst_n` low during operation gives the R1 output state at once, with no clock edge needed. After release, the R5 start-up sequence begins again from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External measurement clock; its level selects the output slot |
| rst_n | input | 1 | Active-low supply-good / reset, asynchronous assert |
| v_en | input | 1 | Voltage slot enable |
| v_bs | input | 1 | Voltage modulator bitstream |
| c_bs | input | 1 | Current modulator bitstream |
| dat | output | 1 | Interleaved serial data |
| datn | output | 1 | Complement of `dat` |
| ph1 | output | 1 | Conversion phase 1 |
| ph2 | output | 1 | Conversion phase 2 |
| vchop | output | 1 | Voltage-path chopper clock |
| cchop_a | output | 1 | Current-path chopper clock, leading |
| cchop_b | output | 1 | Current-path chopper clock, lagging by one cycle |

## Verification
A wrong internal count moves every symptom at once. Bits appear in the serial stream at the wrong edges and the two phases swap. Both show up within one clock cycle. The chopper clocks then take the wrong shape or lose their one-cycle offset within four cycles. A stale or wrongly enabled holding register shows up as a wrong value in one slot of `dat` in the first cycle after a sampling edge it should have obeyed. An output-stage fault shows up in whichever half-cycle it affects: a disabled voltage slot that is not forced to 0, or a complement that is not the inverse.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;

   // slot order inside the interleaved stream; index into bitstream vectors
   typedef enum logic {
      CH_VOLT = 1'b0,
      CH_CURR = 1'b1
   } sdfe_chan_e;

   localparam int unsigned SDFE_NCHAN = 2;

   // derived chopper clocks, bundled
   typedef struct packed {
      logic v;   // voltage path
      logic a;   // current path, leading
      logic b;   // current path, lagging
   } sdfe_chop_t;

endpackage

// File: rtl/sdfe_clkgen.sv
module sdfe_clkgen
   import sdfe_pkg::*;
#(
   parameter int unsigned CHOP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       run,
   output logic       odd,
   output logic       ph1,
   output logic       ph2,
   output sdfe_chop_t chop
);

   localparam int unsigned CNT_W = CHOP_LOG2;

   if (CHOP_LOG2 < 2) begin : g_bad_param
      $error("sdfe_clkgen: CHOP_LOG2 must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   sdfe_chop_t       chop_nxt;

   // first edge after reset only arms the block
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= 1'b1;
   end

   assign cnt_nxt = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (run) cnt_q <= cnt_nxt;
   end

   // quadrature choppers from the top two counter bits (gray order)
   always_comb begin
      chop_nxt.a = cnt_nxt[CNT_W-1] ^ cnt_nxt[CNT_W-2];
      chop_nxt.b = cnt_nxt[CNT_W-1];
      chop_nxt.v = cnt_nxt[CNT_W-1] ^ cnt_nxt[CNT_W-2];
   end

   // registered so the chopper pins never glitch on counter carries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chop <= '0;
      else if (run) chop <= chop_nxt;
   end

   assign odd = cnt_q[0];

   // non-overlapping phases: each is a half-rate gate on the high level
   assign ph1 = run & clk & cnt_q[0];
   assign ph2 = run & clk & ~cnt_q[0];

endmodule

// File: rtl/sdfe_sampler.sv
module sdfe_sampler
   import sdfe_pkg::*;
#(
   parameter int unsigned NCH = SDFE_NCHAN
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           odd,
   input  logic [NCH-1:0] bs_in,
   output logic [NCH-1:0] bs_q
);

   if (NCH != 2) begin : g_bad_param
      $error("sdfe_sampler: exactly two channels are interleaved");
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic SLOT = 1'(g % 2);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bs_q[g] <= 1'b0;
         else if (run && (odd == SLOT))
            bs_q[g] <= bs_in[g];
      end
   end

endmodule

// File: rtl/sdfe_outmux.sv
module sdfe_outmux #(
   parameter bit DIS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic run,
   input  logic v_en,
   input  logic v_q,
   input  logic c_q,
   output logic dat,
   output logic datn
);

   logic v_slot;

   if (DIS_LEVEL) begin : g_dis_one
      assign v_slot = v_q | ~v_en;
   end else begin : g_dis_zero
      assign v_slot = v_q & v_en;
   end

   // one mux level after the clock pin keeps clock-to-data short
   assign dat  = run & (clk ? v_slot : c_q);
   assign datn = ~dat;

endmodule

// File: rtl/sdfe_top.sv
module sdfe_top
   import sdfe_pkg::*;
#(
   parameter int unsigned CHOP_LOG2 = 2,
   parameter bit          DIS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic v_en,
   input  logic v_bs,
   input  logic c_bs,
   output logic dat,
   output logic datn,
   output logic ph1,
   output logic ph2,
   output logic vchop,
   output logic cchop_a,
   output logic cchop_b
);

   localparam int unsigned NCH = SDFE_NCHAN;

   logic           run;
   logic           odd;
   sdfe_chop_t     chop;
   logic [NCH-1:0] bs_in;
   logic [NCH-1:0] bs_q;
   logic           v_q;
   logic           c_q;

   sdfe_clkgen #(.CHOP_LOG2(CHOP_LOG2)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .odd   (odd),
      .ph1   (ph1),
      .ph2   (ph2),
      .chop  (chop)
   );

   assign bs_in[CH_VOLT] = v_bs;
   assign bs_in[CH_CURR] = c_bs;

   sdfe_sampler #(.NCH(NCH)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .odd   (odd),
      .bs_in (bs_in),
      .bs_q  (bs_q)
   );

   assign v_q = bs_q[CH_VOLT];
   assign c_q = bs_q[CH_CURR];

   sdfe_outmux #(.DIS_LEVEL(DIS_LEVEL)) u_outmux (
      .clk  (clk),
      .run  (run),
      .v_en (v_en),
      .v_q  (v_q),
      .c_q  (c_q),
      .dat  (dat),
      .datn (datn)
   );

   assign vchop   = chop.v;
   assign cchop_a = chop.a;
   assign cchop_b = chop.b;

endmodule

// File: rtl/sdfe_chk.sv
module sdfe_chk (
   input logic clk,
   input logic rst_n,
   input logic v_en,
   input logic dat,
   input logic datn,
   input logic ph1,
   input logic ph2,
   input logic vchop,
   input logic cchop_a,
   input logic cchop_b,
   input logic v_q,
   input logic c_q,
   input logic odd
);

   AST_RST_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!dat && datn && !ph1 && !ph2 && !vchop && !cchop_a && !cchop_b)); // R1

   AST_DATN_INV: assert property (@(negedge clk) disable iff (!rst_n)
      datn == !dat); // R4

   AST_VSLOT_OFF: assert property (@(negedge clk) disable iff (!rst_n)
      !v_en |-> !dat); // R8

   AST_PH_EXCL: assert property (@(negedge clk) disable iff (!rst_n)
      !(ph1 && ph2)); // R6

   AST_PH_ALT: assert property (@(negedge clk) disable iff (!rst_n)
      ph1 |=> !ph1); // R6

   AST_CHOP_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(cchop_a) |-> $stable(cchop_b)); // R7

   AST_CHOP_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(cchop_b) |=> $stable(cchop_b)); // R7

   AST_VCHOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(vchop) |-> odd); // R7

   AST_VSAMPLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(v_q) |-> odd); // R5

   AST_CSAMPLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(c_q) |-> !odd); // R5

endmodule

bind sdfe_top sdfe_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .v_en    (v_en),
   .dat     (dat),
   .datn    (datn),
   .ph1     (ph1),
   .ph2     (ph2),
   .vchop   (vchop),
   .cchop_a (cchop_a),
   .cchop_b (cchop_b),
   .v_q     (v_q),
   .c_q     (c_q),
   .odd     (odd)
);

// File: tb/sim_sdfe_top.sv
`timescale 1ns/1ps
module sim_sdfe_top;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic v_en  = 1'b1;
   logic v_bs  = 1'b0;
   logic c_bs  = 1'b0;
   logic dat, datn, ph1, ph2, vchop, cchop_a, cchop_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sdfe_top u0 (
      .clk(clk), .rst_n(rst_n), .v_en(v_en), .v_bs(v_bs), .c_bs(c_bs),
      .dat(dat), .datn(datn), .ph1(ph1), .ph2(ph2),
      .vchop(vchop), .cchop_a(cchop_a), .cchop_b(cchop_b)
   );

   // expectation state built from R5/R7 (edge numbering after reset release)
   logic       m_run;
   logic [1:0] m_cnt;
   logic       m_v, m_c;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run <= 1'b0; m_cnt <= 2'd0; m_v <= 1'b0; m_c <= 1'b0;
      end else if (!m_run) begin
         m_run <= 1'b1;
      end else begin
         if (m_cnt[0] == 1'b0) m_v <= v_bs; else m_c <= c_bs;
         m_cnt <= m_cnt + 2'd1;
      end
   end

   task automatic cmp(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // full comparison of every output in the current half-cycle
   task automatic slot_check(input string rst_tag);
      logic e_dat, e_ca, e_cb;
      string t_dat;
      if (!m_run) begin
         e_dat = 1'b0; e_ca = 1'b0; e_cb = 1'b0;
      end else begin
         e_dat = clk ? (v_en & m_v) : m_c;
         e_ca  = m_cnt[0] ^ m_cnt[1];
         e_cb  = m_cnt[1];
      end
      if (!rst_n)     t_dat = rst_tag;
      else if (!clk)  t_dat = "R3";
      else if (!v_en) t_dat = "R8";
      else            t_dat = "R2";
      cmp(t_dat, "dat", dat, e_dat);
      cmp(rst_n ? "R4" : rst_tag, "datn", datn, ~e_dat);
      cmp(rst_n ? "R6" : rst_tag, "ph1", ph1, m_run & clk & m_cnt[0]);
      cmp(rst_n ? "R6" : rst_tag, "ph2", ph2, m_run & clk & ~m_cnt[0]);
      cmp(rst_n ? "R7" : rst_tag, "cchop_a", cchop_a, e_ca);
      cmp(rst_n ? "R7" : rst_tag, "cchop_b", cchop_b, e_cb);
      cmp(rst_n ? "R7" : rst_tag, "vchop", vchop, e_ca);
   endtask

   // called at negedge+5; drives, then checks both slots of one cycle
   task automatic cycle(input logic vin, input logic cin, input logic en, input string rst_tag);
      v_bs = vin; c_bs = cin; v_en = en;
      @(posedge clk); #5; slot_check(rst_tag);
      @(negedge clk); #5; slot_check(rst_tag);
   endtask

   task automatic t_reset_state;   // R1
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, i[0], "R1");
   endtask

   task automatic t_startup;   // R5: edge 1 samples nothing
      rst_n = 1'b1;
      v_bs = 1'b1; c_bs = 1'b1; v_en = 1'b1;
      @(posedge clk); #5;
      cmp("R5", "dat after start edge", dat, 1'b0);
      cmp("R5", "ph1 after start edge", ph1, 1'b0);
      @(negedge clk); #5;
      cmp("R5", "dat low slot after start edge", dat, 1'b0);
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b1, "R1");
   endtask

   task automatic t_streams;   // R2 R3 R4 R6 R7 under varied data
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 16; i++) cycle(1'b1, 1'b0, 1'b1, "R1");
      for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, 1'b1, "R1");
      for (int i = 0; i < 60; i++) begin
         cycle(lfsr[0], lfsr[3], 1'b1, "R1");
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
   endtask

   task automatic t_half_rate;   // R5: values offered off the sampling edges never appear
      for (int i = 0; i < 24; i++) begin
         v_bs = (m_cnt[0] == 1'b0) ? 1'b0 : 1'b1;
         c_bs = (m_cnt[0] == 1'b1) ? 1'b1 : 1'b0;
         @(posedge clk); #5;
         if (i >= 2) cmp("R5", "dat held voltage", dat, 1'b0);
         @(negedge clk); #5;
         if (i >= 2) cmp("R5", "dat held current", dat, 1'b1);
      end
   endtask

   task automatic t_disable;   // R8
      logic [7:0] lfsr = 8'h3C;
      for (int i = 0; i < 20; i++) begin
         cycle(1'b1, lfsr[2], 1'b0, "R1");
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b1, "R1");
   endtask

   task automatic t_midreset;   // R9
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b1, "R9");
      @(posedge clk); #3;
      rst_n = 1'b0; #1;
      cmp("R9", "dat immediate", dat, 1'b0);
      cmp("R9", "datn immediate", datn, 1'b1);
      cmp("R9", "ph1/ph2 immediate", ph1 | ph2, 1'b0);
      cmp("R9", "choppers immediate", vchop | cchop_a | cchop_b, 1'b0);
      @(negedge clk); #5;
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b1, "R9");
      rst_n = 1'b1;
      @(posedge clk); #5;
      cmp("R9", "dat after restart edge", dat, 1'b0);
      @(negedge clk); #5;
      for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, 1'b1, "R9");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      finish_run();
   end

   initial begin
      @(negedge clk); #5;
      t_reset_state();
      t_startup();
      t_streams();
      t_half_rate();
      t_disable();
      t_midreset();
      finish_run();
   end

endmodule